// File: doc/BRIEF.md
# Single-Wire Bus Device Signalling Engine

This block is the device-side signalling engine for a single open-drain wire with an external pull-up. It reads a synchronized copy of the wire and acts on it. A long low level from the master counts as a bus reset. After the wire rises again, the block waits a fixed delay and then pulls the wire low to announce that it is present. Once that announcement has finished, every falling edge made by the master opens a time slot. In a write slot the block samples the wire once to recover a bit. In a read slot it holds the wire low when it sends a 0.

The layer above works one bit at a time. Before each slot it sets `slot_rd` to choose the slot type and `tx_bit` to give the bit to send. Each write slot returns one bit on `rx_bit`, with a one-cycle `rx_valid` strobe. All timing comes from a microsecond tick derived from the `CLK_HZ` parameter. The block never drives the wire high. Its only output toward the wire is an active-low pull-down enable.

Top module: `owire_slave_phy`

## Requirements
- R1: After `rst_n` is deasserted, `dq_drv_n` is 1 and `rx_valid` is 0. Until a bus reset has been seen and its presence pulse has completed, falling edges on the wire produce no strobe and no pull-down.
- R2: The wire (after the two-flop synchronizer) held low for at least RST_MIN_US (480 us) counts as a bus reset. A low period shorter than that is not a reset.
- R3: Once the wire rises after a bus reset, `dq_drv_n` goes to 0 after PDH_US (30 us). It stays 0 for PDL_US (120 us) and is then released to 1.
- R4: After the presence pulse, each falling edge of the wire starts one slot. At that edge the block captures `slot_rd` (1 = read slot, 0 = write slot) and `tx_bit`.
- R5: In a write slot the block samples the wire WR_SAMPLE_US (30 us) after the falling edge. It then gives exactly one single-cycle `rx_valid` pulse, with `rx_bit` equal to the sampled level (1 for high, 0 for low). A write slot never pulls the wire low.
- R6: In a read slot with `tx_bit` = 0, `dq_drv_n` is 0 from the start of the slot until RD_HOLD_US (45 us) after the falling edge. The wire is therefore low at 15 us. No `rx_valid` is produced.
- R7: In a read slot with `tx_bit` = 1, `dq_drv_n` stays 1 for the whole slot, so the wire is high at 15 us once the master has let go.
- R8: A low period reaching the reset length during or after a slot overrides the slot. The pull-down is released, no further strobe is given, and a fresh presence pulse follows when the wire rises.
- R9: `dq_drv_n` is 0 only during a presence pulse or a read slot sending 0.
- R10: The next slot is accepted even when the master leaves the wire high for a single clock between slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low block reset |
| dq_i | input | 1 | Raw wire level (asynchronous) |
| dq_drv_n | output | 1 | Pull-down enable, 0 pulls the wire low |
| slot_rd | input | 1 | Type of the next slot: 1 read, 0 write |
| tx_bit | input | 1 | Bit to send in the next read slot |
| rx_bit | output | 1 | Bit recovered in the last write slot |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_bit` |

## Verification
Two things can land on adjacent cycles: the slot engine leaving its end-of-slot wait, and the next falling edge opening a new slot. If the master allows very little recovery, the cycle in which the wire is first seen high is also the last chance to arm for the next edge. The bench sweeps the high gap between slots from one to four clocks over every 4-bit write pattern and every 4-bit read pattern. For each slot it judges the result by the exact count of strobes, the value of each recovered bit, and the wire level at 15 us. The bench also runs the bus reset just below and just above its length threshold, and once on a wire held low in the middle of a read slot.

// File: rtl/owire_phy_pkg.sv
package owire_phy_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,   // no bus reset seen yet
        ST_RST,    // reset low in progress
        ST_PDH,    // delay before presence
        ST_PDL,    // presence pull-down
        ST_PDREL,  // wait for wire high after presence
        ST_IDLE,   // armed for a slot
        ST_SLOT,   // slot timing in progress
        ST_REC     // wait for wire high after slot
    } phy_st_e;

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{INIT}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/owire_ustick.sv
module owire_ustick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owire_lowtimer.sv
module owire_lowtimer #(
    parameter int LIMIT = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_low,
    output logic hit
);
    localparam int LW = $clog2(LIMIT + 1);

    logic [LW-1:0] cnt_d, cnt_q;

    assign hit = line_low && (cnt_q == LW'(LIMIT - 1));

    always_comb begin
        if (!line_low)                  cnt_d = '0;
        else if (cnt_q == LW'(LIMIT))   cnt_d = cnt_q;
        else                            cnt_d = cnt_q + LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy
    import owire_phy_pkg::*;
#(
    parameter int CLK_HZ       = 250_000_000,
    parameter int RST_MIN_US   = 480,
    parameter int PDH_US       = 30,
    parameter int PDL_US       = 120,
    parameter int WR_SAMPLE_US = 30,
    parameter int RD_HOLD_US   = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dq_i,
    output logic dq_drv_n,
    input  logic slot_rd,
    input  logic tx_bit,
    output logic rx_bit,
    output logic rx_valid
);
    localparam int DIV     = CLK_HZ / 1_000_000;
    localparam int RST_CYC = RST_MIN_US * DIV;
    localparam int MAX_A   = (PDH_US > PDL_US) ? PDH_US : PDL_US;
    localparam int MAX_B   = (WR_SAMPLE_US > RD_HOLD_US) ? WR_SAMPLE_US : RD_HOLD_US;
    localparam int MAX_US  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W   = $clog2(MAX_US + 2);

    localparam logic [TMR_W-1:0] PDH_END = TMR_W'(PDH_US - 1);
    localparam logic [TMR_W-1:0] PDL_END = TMR_W'(PDL_US - 1);
    localparam logic [TMR_W-1:0] WR_END  = TMR_W'(WR_SAMPLE_US - 1);
    localparam logic [TMR_W-1:0] RD_END  = TMR_W'(RD_HOLD_US - 1);

    typedef struct packed {
        phy_st_e          st;
        logic [TMR_W-1:0] tmr;
        logic             rd;
        logic             txb;
        logic             drv;
        logic             rxb;
        logic             rxv;
        logic             prev;
    } phy_reg_t;

    localparam phy_reg_t REG_RST = '{
        st: ST_WAIT, tmr: '0, rd: 1'b0, txb: 1'b1,
        drv: 1'b0, rxb: 1'b0, rxv: 1'b0, prev: 1'b1
    };

    phy_reg_t r_d, r_q;
    logic     dq_s;
    logic     tick;
    logic     restart;
    logic     rst_hit;
    logic     fell;

    owire_sync #(.STAGES(2), .INIT(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dq_i),
        .q     (dq_s)
    );

    owire_ustick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick)
    );

    owire_lowtimer #(.LIMIT(RST_CYC)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_low (!dq_s),
        .hit      (rst_hit)
    );

    assign fell = r_q.prev && !dq_s;

    always_comb begin
        r_d      = r_q;
        r_d.rxv  = 1'b0;
        r_d.prev = dq_s;
        restart  = 1'b0;
        if (tick) r_d.tmr = r_q.tmr + TMR_W'(1);

        unique case (r_q.st)
            ST_WAIT: begin
                r_d.drv = 1'b0;
            end
            ST_RST: begin
                r_d.drv = 1'b0;
                if (dq_s) begin
                    r_d.st  = ST_PDH;
                    restart = 1'b1;
                end
            end
            ST_PDH: begin
                if (tick && r_q.tmr == PDH_END) begin
                    r_d.st  = ST_PDL;
                    r_d.drv = 1'b1;
                    restart = 1'b1;
                end
            end
            ST_PDL: begin
                if (tick && r_q.tmr == PDL_END) begin
                    r_d.st  = ST_PDREL;
                    r_d.drv = 1'b0;
                end
            end
            ST_PDREL: begin
                if (dq_s) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (fell) begin
                    r_d.st  = ST_SLOT;
                    r_d.rd  = slot_rd;
                    r_d.txb = tx_bit;
                    r_d.drv = slot_rd && !tx_bit;
                    restart = 1'b1;
                end
            end
            ST_SLOT: begin
                if (!r_q.rd) begin
                    if (tick && r_q.tmr == WR_END) begin
                        r_d.rxb = dq_s;
                        r_d.rxv = 1'b1;
                        r_d.st  = ST_REC;
                    end
                end else begin
                    if (tick && r_q.tmr == RD_END) begin
                        r_d.drv = 1'b0;
                        r_d.st  = ST_REC;
                    end
                end
            end
            ST_REC: begin
                r_d.drv = 1'b0;
                if (dq_s) r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st  = ST_WAIT;
                r_d.drv = 1'b0;
            end
        endcase

        if (restart) r_d.tmr = '0;

        if (rst_hit) begin
            r_d.st  = ST_RST;
            r_d.drv = 1'b0;
            r_d.rxv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    assign dq_drv_n = !r_q.drv;
    assign rx_bit   = r_q.rxb;
    assign rx_valid = r_q.rxv;

endmodule

// File: rtl/owire_phy_chk.sv
module owire_phy_chk
    import owire_phy_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input phy_st_e st,
    input logic    mode_rd,
    input logic    dq_drv_n,
    input logic    rx_valid
);
    // R5: strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a strobe only follows slot timing
    a_r5_strobe_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(st) == ST_SLOT);

    // R5: write slots never pull the wire
    a_r5_write_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLOT && !mode_rd) |-> dq_drv_n);

    // R9: pull-down only in presence or read slot
    a_r9_pull_scope: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_drv_n |-> (st == ST_PDL || (st == ST_SLOT && mode_rd)));

    // R8: reset phase is quiet
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RST) |-> (dq_drv_n && !rx_valid));

    // R1: nothing happens before the first bus reset
    a_r1_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (dq_drv_n && !rx_valid));

    // R3: presence is entered only from the delay phase
    a_r3_presence_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDL) |-> ($past(st) == ST_PDH || $past(st) == ST_PDL));
endmodule

bind owire_slave_phy owire_phy_chk u_phy_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (r_q.st),
    .mode_rd  (r_q.rd),
    .dq_drv_n (dq_drv_n),
    .rx_valid (rx_valid)
);

// File: tb/test_owire_slave_phy.sv
module test_owire_slave_phy;
    localparam int DIV     = 4;
    localparam int RST_US  = 480;
    localparam int PDH_US  = 30;
    localparam int PDL_US  = 120;
    localparam int PD_DLY  = 3 + PDH_US * DIV;
    localparam int PD_LEN  = PDL_US * DIV;
    localparam int RST_CYC = RST_US * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_rel = 1'b1;
    logic dq_i;
    logic dq_drv_n;
    logic slot_rd = 1'b0;
    logic tx_bit = 1'b1;
    logic rx_bit;
    logic rx_valid;

    int n_chk = 0;
    int n_fail = 0;
    int rx_cnt = 0;
    logic rx_last = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign dq_i = m_rel & dq_drv_n;

    owire_slave_phy #(.CLK_HZ(DIV * 1_000_000)) i_owire_slave_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .dq_i     (dq_i),
        .dq_drv_n (dq_drv_n),
        .slot_rd  (slot_rd),
        .tx_bit   (tx_bit),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_bit;
        end
    end

    task automatic chk_eq(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", rq, act, lo, hi);
        end
    endtask

    // Hold the wire low, release it and judge the presence answer.
    task automatic bus_reset(input int low_cyc, input bit want_pd, input string rq);
        int dly;
        int wid;
        @(negedge clk) m_rel = 1'b0;
        repeat (low_cyc) @(negedge clk);
        m_rel = 1'b1;
        dly = 0;
        while (dq_drv_n && dly < PD_DLY + 400) begin
            @(negedge clk);
            dly++;
        end
        if (want_pd) begin
            chk_rng(rq, dly, PD_DLY - 2, PD_DLY + 2);
            wid = 0;
            while (!dq_drv_n && wid < PD_LEN + 50) begin
                wid++;
                @(negedge clk);
            end
            chk_rng("R3", wid, PD_LEN - 2, PD_LEN + 2);
        end else begin
            chk_eq(rq, dq_drv_n, 1);
        end
        repeat (20) @(negedge clk);
    endtask

    // Master write slot: 240 cycles (60 us), then gap cycles of high wire.
    task automatic write_slot(input bit b, input int gap, input int exp_inc, input string rq);
        int c0;
        bit pulled;
        c0 = rx_cnt;
        pulled = 1'b0;
        slot_rd = 1'b0;
        tx_bit  = 1'b1;
        m_rel   = 1'b0;
        for (int n = 1; n <= 240; n++) begin
            @(negedge clk);
            if (n == 8 && b) m_rel = 1'b1;
            if (!dq_drv_n) pulled = 1'b1;
        end
        m_rel = 1'b1;
        chk_eq(rq, rx_cnt - c0, exp_inc);
        if (exp_inc == 1) chk_eq("R5", rx_last, b);
        chk_eq("R5", pulled, 0);
        repeat (gap) @(negedge clk);
    endtask

    // Master read slot: pull low 1 us, sample at 15 us.
    task automatic read_slot(input bit b, input int gap, input bit armed);
        int c0;
        bit pulled;
        logic at15;
        logic at42;
        logic at48;
        c0 = rx_cnt;
        pulled = 1'b0;
        at15 = 1'b0;
        at42 = 1'b1;
        at48 = 1'b1;
        slot_rd = 1'b1;
        tx_bit  = b;
        m_rel   = 1'b0;
        for (int n = 1; n <= 240; n++) begin
            @(negedge clk);
            if (n == 4) m_rel = 1'b1;
            if (n == 60)  at15 = dq_i;
            if (n == 170) at42 = dq_drv_n;
            if (n == 195) at48 = dq_drv_n;
            if (!dq_drv_n) pulled = 1'b1;
        end
        chk_eq("R4", rx_cnt - c0, 0);
        if (!armed) begin
            chk_eq("R1", pulled, 0);
        end else if (b) begin
            chk_eq("R7", at15, 1);
            chk_eq("R7", pulled, 0);
        end else begin
            chk_eq("R6", at15, 0);
            chk_eq("R6", at42, 0);
            chk_eq("R6", at48, 1);
        end
        slot_rd = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", dq_drv_n, 1);
        chk_eq("R1", rx_valid, 0);

        // Slots before any bus reset are ignored.
        write_slot(1'b0, 8, 0, "R1");
        read_slot(1'b0, 8, 1'b0);

        // Just under the reset length: no presence.
        bus_reset(RST_CYC - 4, 1'b0, "R2");
        write_slot(1'b1, 8, 0, "R2");

        // Just over the reset length: presence with exact timing.
        bus_reset(RST_CYC + 4, 1'b1, "R2");

        // Every 4-bit write pattern, recovery gap 1..4 clocks.
        for (int v = 0; v < 16; v++) begin
            for (int k = 0; k < 4; k++) begin
                write_slot(v[k], 1 + ((v + k) % 4), 1, "R10");
            end
        end

        // Every 4-bit read pattern, recovery gap 1..4 clocks.
        for (int v = 0; v < 16; v++) begin
            for (int k = 0; k < 4; k++) begin
                read_slot(v[k], 1 + ((v + k) % 4), 1'b1);
            end
        end

        // Mixed order: write right after read.
        read_slot(1'b0, 1, 1'b1);
        write_slot(1'b0, 1, 1, "R4");
        write_slot(1'b1, 2, 1, "R4");

        // Reset in the middle of a read slot sending 0.
        c0 = rx_cnt;
        slot_rd = 1'b1;
        tx_bit  = 1'b0;
        bus_reset(RST_CYC + 80, 1'b1, "R8");
        chk_eq("R8", rx_cnt - c0, 0);
        write_slot(1'b1, 4, 1, "R8");
        write_slot(1'b0, 4, 1, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule